// File: doc/BRIEF.md
# Memory Map Decoder with Bus Sequencer

This block takes one read or write request at a time, of byte, word (16-bit) or long (32-bit) size, on a 24-bit byte address. It decides from the address whether each byte belongs to a small boot ROM, to an internal RAM, or to an external device port, and it runs the request as a series of smaller accesses. Values are big-endian: the lowest address carries the most significant byte.

A long request becomes two word accesses, first at the request address and then at that address plus two. A word access whose address lies below the device region becomes two single-byte steps, because ROM and RAM are byte-wide. A word access inside the device region goes out as one 16-bit device transaction. The first eight byte addresses are an alias of the start of the ROM, so reset vectors can be fetched from there. Writes into either ROM window are dropped without any error. Reads from the RAM window above the populated RAM return all-ones. A request is accepted only while the block is idle, and a one-cycle done pulse marks its completion.

The device side uses a request/acknowledge handshake. The block holds the request and its fields until the acknowledge arrives, and it takes the read data in the acknowledge cycle.

Top module: `mm_bus_top`

## Requirements
- R1: While reset is active and afterwards until a request arrives, busy_o, done_o and dev_req_o are all 0.
- R2: Byte addresses 0x000000 to 0x000007 read the ROM byte at the same index. The ROM byte at index k is (90 + 29*k) mod 256, where k runs from 0 to ROM_BYTES-1 (64 by default).
- R3: Addresses 0x7E0000 to 0x7FFFFF read the ROM at index (address − 0x7E0000) mod ROM_BYTES.
- R4: Addresses 0x000008 up to 0x7DFFFF are RAM. Below RAM_BYTES (256 by default) they can be written and read back, and RAM reads 0 after reset. At or above RAM_BYTES, reads return 0xFF and writes have no effect.
- R5: A write to address 0x000000–0x000007 or 0x7E0000–0x7FFFFF changes nothing that a later read can see.
- R6: Addresses at or above 0x800000 go to the device port. size_i encodes the request size: 0 is byte, 1 is word, 2 or 3 is long. A byte request makes one byte transaction (dev_wide_o=0, data on bits 7:0). A word request makes one word transaction (dev_wide_o=1). A long request makes two word transactions, at a and then at a+2.
- R7: A word at address a has the byte at a in bits 15:8 and the byte at a+1 in bits 7:0, for both reads and writes.
- R8: A long at address a has the word at a in bits 31:16 and the word at a+2 in bits 15:0.
- R9: A request that touches no byte at or above 0x800000 takes one cycle per byte. A request accepted at clock edge E raises done_o after edge E+1 for a byte, E+2 for a word and E+4 for a long.
- R10: done_o pulses for exactly one cycle per accepted request. A request presented while busy_o is 1 is ignored.
- R11: While dev_req_o is 1 and dev_ack_i is 0, the address, width, direction and write data on the device port stay stable.
- R12: Each byte of a word below 0x800000 is routed by its own address. A word read at 0x7FFFFF takes its high byte from the ROM and its low byte from one device byte transaction at 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2/3 long |
| addr_i | input | 24 | Byte address of the request |
| wdata_i | input | 32 | Write value, right-aligned |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read value, right-aligned, valid from done_o until the next accept |
| dev_req_o | output | 1 | Device transaction request |
| dev_we_o | output | 1 | Device transaction is a write |
| dev_wide_o | output | 1 | 1 = 16-bit, 0 = 8-bit transaction |
| dev_addr_o | output | 24 | Device transaction byte address |
| dev_wdata_o | output | 16 | Device write data (byte on bits 7:0) |
| dev_ack_i | input | 1 | Device completes the transaction this cycle |
| dev_rdata_i | input | 16 | Device read data (byte on bits 7:0) |

## Verification
On every cycle, the assertions check that the device fields stay stable while a transaction waits for its acknowledge, that device traffic only goes to addresses in the device region, that done is a single pulse following a busy period, that nothing moves while idle, and that RAM is never written through a ROM window. The bench scenarios cover what a per-cycle property cannot see: the ROM and RAM contents returned through each window, the big-endian assembly and splitting of words and longs, the fill value of unpopulated RAM, the dropped ROM writes read back afterwards, the exact step latency, the number and shape of device transactions for each size, and the word that straddles the ROM/device boundary.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_ROM = 2'd0,
    RG_RAM = 2'd1,
    RG_DEV = 2'd2
  } region_e;

  // size codes 2 and 3 both mean a 32-bit access
  function automatic acc_size_e norm_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_WORD;
      default: return SZ_LONG;
    endcase
  endfunction

  // moves the write value to the top so the first byte out is the most significant
  function automatic logic [31:0] align_wdata(input acc_size_e sz, input logic [31:0] d);
    case (sz)
      SZ_BYTE: return {d[7:0], 24'h000000};
      SZ_WORD: return {d[15:0], 16'h0000};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] shift_in_byte(input logic [31:0] acc, input logic [7:0] b);
    return {acc[23:0], b};
  endfunction

  function automatic logic [31:0] shift_in_word(input logic [31:0] acc, input logic [15:0] w);
    return {acc[15:0], w};
  endfunction

  // boot image byte at index k
  function automatic logic [7:0] rom_image(input int unsigned k);
    int unsigned v;
    v = (k * 29 + 90) % 256;
    return v[7:0];
  endfunction

endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned RAM_BYTES   = 256,
  parameter int unsigned LOW_ROM_END = 8,
  parameter int unsigned ROM_HI_BASE = 32'h007E_0000,
  parameter int unsigned DEV_BASE    = 32'h0080_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] rom_off_o,
  output logic              ram_fill_o
);

  localparam logic [ADDR_W-1:0] LOW_END_A = ADDR_W'(LOW_ROM_END);
  localparam logic [ADDR_W-1:0] HI_BASE_A = ADDR_W'(ROM_HI_BASE);
  localparam logic [ADDR_W-1:0] DEV_A     = ADDR_W'(DEV_BASE);
  localparam logic [ADDR_W-1:0] RAM_LIM_A = ADDR_W'(RAM_BYTES);

  always_comb begin
    region_o  = RG_DEV;
    rom_off_o = '0;
    if (addr_i < LOW_END_A) begin
      region_o  = RG_ROM;
      rom_off_o = addr_i;
    end else if (addr_i < HI_BASE_A) begin
      region_o  = RG_RAM;
    end else if (addr_i < DEV_A) begin
      region_o  = RG_ROM;
      rom_off_o = addr_i - HI_BASE_A;
    end
  end

  assign ram_fill_o = (addr_i < RAM_LIM_A);

endmodule

// File: rtl/mm_store.sv
module mm_store
  import mm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned RAM_BYTES   = 256,
  parameter int unsigned ROM_BYTES   = 64,
  parameter int unsigned LOW_ROM_END = 8,
  parameter int unsigned ROM_HI_BASE = 32'h007E_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  region_e           region_i,
  input  logic [ADDR_W-1:0] rom_off_i,
  input  logic              ram_fill_i,
  input  logic [7:0]        wbyte_i,
  output logic [7:0]        rbyte_o,
  output logic              ram_wr_o
);

  localparam int unsigned RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam int unsigned ROM_AW = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;

  logic [7:0] rom_arr [ROM_BYTES];
  logic [7:0] ram_arr [RAM_BYTES];

  for (genvar k = 0; k < ROM_BYTES; k++) begin : g_rom
    assign rom_arr[k] = rom_image(k);
  end

  logic [RAM_AW-1:0] ram_idx;
  logic [ROM_AW-1:0] rom_idx;

  assign ram_idx  = addr_i[RAM_AW-1:0];
  assign rom_idx  = rom_off_i[ROM_AW-1:0];
  assign ram_wr_o = en_i && we_i && (region_i == RG_RAM) && ram_fill_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_BYTES; i++) ram_arr[i] <= 8'h00;
    end else if (ram_wr_o) begin
      ram_arr[ram_idx] <= wbyte_i;
    end
  end

  always_comb begin
    case (region_i)
      RG_ROM:  rbyte_o = rom_arr[rom_idx];
      RG_RAM:  rbyte_o = ram_fill_i ? ram_arr[ram_idx] : 8'hFF;
      default: rbyte_o = 8'h00;
    endcase
  end

  // storage is only written through the RAM window
  assert_rom_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_o |-> (addr_i >= ADDR_W'(LOW_ROM_END)) && (addr_i < ADDR_W'(ROM_HI_BASE)));

endmodule

// File: rtl/mm_bus_seq.sv
module mm_bus_seq
  import mm_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic [ADDR_W-1:0] step_addr_o,
  input  logic              step_dev_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wbyte_o,
  input  logic [7:0]        mem_rbyte_i,
  output logic              dev_req_o,
  output logic              dev_we_o,
  output logic              dev_wide_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [15:0]       dev_wdata_o,
  input  logic              dev_ack_i,
  input  logic [15:0]       dev_rdata_i,
  output logic              step_fire_o,
  output logic              last_step_o
);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  seq_state_e        st_q;
  logic [ADDR_W-1:0] base_q;
  acc_size_e         sz_q;
  logic              we_q;
  logic              half_q;
  logic              sub_q;
  logic [31:0]       wsh_q;
  logic [31:0]       acc_q;
  logic              done_q;

  logic              run;
  logic              byte_req;
  logic              wide;
  logic              word_end;
  logic [ADDR_W-1:0] word_addr;
  logic [7:0]        byte_in;

  assign run       = (st_q == ST_RUN);
  assign byte_req  = (sz_q == SZ_BYTE);
  assign word_addr = base_q + (half_q ? ADDR_W'(2) : ADDR_W'(0));

  // word-level address on the first step of a word, so the decoder picks
  // device-word versus byte stepping from it
  assign step_addr_o = byte_req ? base_q : word_addr + ADDR_W'(sub_q);

  assign wide        = !byte_req && !sub_q && step_dev_i;
  assign step_fire_o = run && (!step_dev_i || dev_ack_i);
  assign word_end    = byte_req || wide || sub_q;
  assign last_step_o = word_end && ((sz_q != SZ_LONG) || half_q);

  assign mem_en_o    = run && !step_dev_i;
  assign mem_we_o    = mem_en_o && we_q;
  assign mem_wbyte_o = wsh_q[31:24];

  assign dev_req_o   = run && step_dev_i;
  assign dev_we_o    = run && we_q;
  assign dev_wide_o  = wide;
  assign dev_addr_o  = step_addr_o;
  assign dev_wdata_o = wide ? wsh_q[31:16] : {8'h00, wsh_q[31:24]};

  assign byte_in = step_dev_i ? dev_rdata_i[7:0] : mem_rbyte_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      sz_q   <= SZ_BYTE;
      we_q   <= 1'b0;
      half_q <= 1'b0;
      sub_q  <= 1'b0;
      wsh_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (req_i) begin
          st_q   <= ST_RUN;
          base_q <= addr_i;
          sz_q   <= norm_size(size_i);
          we_q   <= we_i;
          half_q <= 1'b0;
          sub_q  <= 1'b0;
          wsh_q  <= align_wdata(norm_size(size_i), wdata_i);
          acc_q  <= '0;
        end
      end else if (step_fire_o) begin
        acc_q <= wide ? shift_in_word(acc_q, dev_rdata_i) : shift_in_byte(acc_q, byte_in);
        wsh_q <= wide ? {wsh_q[15:0], 16'h0000} : {wsh_q[23:0], 8'h00};
        if (word_end) begin
          sub_q  <= 1'b0;
          half_q <= 1'b1;
        end else begin
          sub_q  <= 1'b1;
        end
        if (last_step_o) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = run;
  assign done_o  = done_q;
  assign rdata_o = acc_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !dev_req_o && !mem_en_o);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_dev_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_o && !dev_ack_i |=> dev_req_o && $stable(dev_addr_o) && $stable(dev_wide_o)
                                && $stable(dev_we_o) && $stable(dev_wdata_o));

endmodule

// File: rtl/mm_bus_top.sv
module mm_bus_top
  import mm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned RAM_BYTES   = 256,
  parameter int unsigned ROM_BYTES   = 64,
  parameter int unsigned LOW_ROM_END = 8,
  parameter int unsigned ROM_HI_BASE = 32'h007E_0000,
  parameter int unsigned DEV_BASE    = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              dev_req_o,
  output logic              dev_we_o,
  output logic              dev_wide_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [15:0]       dev_wdata_o,
  input  logic              dev_ack_i,
  input  logic [15:0]       dev_rdata_i
);

  logic [ADDR_W-1:0] step_addr;
  region_e           step_region;
  logic [ADDR_W-1:0] step_rom_off;
  logic              step_ram_fill;
  logic              step_dev;
  logic              mem_en;
  logic              mem_we;
  logic [7:0]        mem_wbyte;
  logic [7:0]        mem_rbyte;
  logic              ram_wr;
  logic              step_fire;
  logic              last_step;

  assign step_dev = (step_region == RG_DEV);

  mm_decode #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .LOW_ROM_END(LOW_ROM_END),
    .ROM_HI_BASE(ROM_HI_BASE), .DEV_BASE(DEV_BASE)
  ) u_decode (
    .addr_i    (step_addr),
    .region_o  (step_region),
    .rom_off_o (step_rom_off),
    .ram_fill_o(step_ram_fill)
  );

  mm_store #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES),
    .LOW_ROM_END(LOW_ROM_END), .ROM_HI_BASE(ROM_HI_BASE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (mem_en),
    .we_i      (mem_we),
    .addr_i    (step_addr),
    .region_i  (step_region),
    .rom_off_i (step_rom_off),
    .ram_fill_i(step_ram_fill),
    .wbyte_i   (mem_wbyte),
    .rbyte_o   (mem_rbyte),
    .ram_wr_o  (ram_wr)
  );

  mm_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .we_i       (we_i),
    .size_i     (size_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .step_addr_o(step_addr),
    .step_dev_i (step_dev),
    .mem_en_o   (mem_en),
    .mem_we_o   (mem_we),
    .mem_wbyte_o(mem_wbyte),
    .mem_rbyte_i(mem_rbyte),
    .dev_req_o  (dev_req_o),
    .dev_we_o   (dev_we_o),
    .dev_wide_o (dev_wide_o),
    .dev_addr_o (dev_addr_o),
    .dev_wdata_o(dev_wdata_o),
    .dev_ack_i  (dev_ack_i),
    .dev_rdata_i(dev_rdata_i),
    .step_fire_o(step_fire),
    .last_step_o(last_step)
  );

  assert_dev_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_o |-> dev_addr_o >= ADDR_W'(DEV_BASE));

  assert_no_mixed_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && dev_req_o |-> !ram_wr);

  assert_last_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && last_step |=> !busy_o && done_o);

endmodule

// File: tb/sim_mm_bus_top.sv
module sim_mm_bus_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [1:0]  size;
  logic [23:0] addr;
  logic [31:0] wdata;
  logic        busy, done;
  logic [31:0] rdata;
  logic        dev_req, dev_we, dev_wide;
  logic [23:0] dev_addr;
  logic [15:0] dev_wdata;
  logic        dev_ack;
  logic [15:0] dev_rdata;

  always #5 clk = ~clk;

  mm_bus_top u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .size_i(size), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .dev_req_o(dev_req), .dev_we_o(dev_we), .dev_wide_o(dev_wide), .dev_addr_o(dev_addr),
    .dev_wdata_o(dev_wdata), .dev_ack_i(dev_ack), .dev_rdata_i(dev_rdata)
  );

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] exp;
    bit          rd;
    int          lat;
    int          c0;
    string       tag;
  } item_t;
  item_t sb[$];

  typedef struct {
    int a;
    bit wide;
    bit w;
  } tr_t;
  tr_t dq[$];

  logic [7:0] shadow [256];
  logic [7:0] devmem [int];

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // boot image restated as a running sum
  function automatic logic [7:0] rom_ref(input int o);
    logic [7:0] v;
    v = 8'd90;
    for (int i = 0; i < (o % 64); i++) v = v + 8'd29;
    return v;
  endfunction

  function automatic logic [7:0] dev_byte(input int a);
    if (devmem.exists(a)) return devmem[a];
    return 8'(a) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] ref_byte(input int a);
    if (a < 8) return rom_ref(a);
    if (a < 'h7E0000) return (a < 256) ? shadow[a] : 8'hFF;
    if (a < 'h800000) return rom_ref(a - 'h7E0000);
    return dev_byte(a);
  endfunction

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && done === 1'b1) begin
        if (sb.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R10 done without accepted request: actual 1 expected 0");
        end else begin
          it = sb.pop_front();
          if (it.rd) check(it.tag, "rdata", rdata, it.exp);
          if (it.lat >= 0) check("R9", "latency", 32'(cyc - it.c0), 32'(it.lat));
        end
      end
    end
  end

  // device model: acknowledges on the second cycle of a request
  initial begin
    int dcnt;
    logic [23:0] snap_a;
    int a;
    dcnt = 0;
    snap_a = '0;
    dev_ack = 1'b0;
    dev_rdata = '0;
    forever begin
      @(negedge clk);
      if (dev_ack) begin
        dev_ack = 1'b0;
        dcnt = 0;
      end else if (rst_n === 1'b1 && dev_req === 1'b1) begin
        dcnt++;
        if (dcnt == 1) begin
          snap_a = dev_addr;
        end else begin
          check("R11", "device address held", 32'(dev_addr), 32'(snap_a));
          a = int'(dev_addr);
          if (dev_wide) begin
            dev_rdata = {dev_byte(a), dev_byte(a + 1)};
            if (dev_we) begin
              devmem[a]     = dev_wdata[15:8];
              devmem[a + 1] = dev_wdata[7:0];
            end
          end else begin
            dev_rdata = {8'h00, dev_byte(a)};
            if (dev_we) devmem[a] = dev_wdata[7:0];
          end
          dq.push_back('{a: a, wide: dev_wide, w: dev_we});
          dev_ack = 1'b1;
        end
      end
    end
  end

  task automatic start(input bit w, input logic [1:0] sz, input int a, input logic [31:0] d, input string tag);
    item_t it;
    int nb;
    bit intl;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    intl = 1'b1;
    it.exp = '0;
    for (int i = 0; i < nb; i++) begin
      it.exp = {it.exp[23:0], ref_byte(a + i)};
      if (a + i >= 'h800000) intl = 1'b0;
    end
    it.rd  = !w;
    it.lat = intl ? nb : -1;
    it.c0  = cyc + 1;
    it.tag = tag;
    if (w) begin
      for (int i = 0; i < nb; i++) begin
        if (a + i >= 8 && a + i < 256) shadow[a + i] = 8'(d >> (8 * (nb - 1 - i)));
      end
    end
    sb.push_back(it);
    req = 1'b1; we = w; size = sz; addr = 24'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle;
    while (sb.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic op(input bit w, input logic [1:0] sz, input int a, input logic [31:0] d, input string tag);
    wait_idle;
    start(w, sz, a, d, tag);
    wait_idle;
  endtask

  task automatic expect_dev(input string rq, input int n, input int a0, input bit wide0);
    check(rq, "device transaction count", 32'(dq.size()), 32'(n));
    if (dq.size() > 0) begin
      check(rq, "first device address", 32'(dq[0].a), 32'(a0));
      check(rq, "first device width", 32'(dq[0].wide), 32'(wide0));
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; size = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy), 0);
    check("R1", "done in reset", 32'(done), 0);
    check("R1", "dev_req in reset", 32'(dev_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", 32'(busy), 0);

    // low ROM alias
    op(0, 2'd0, 3, 0, "R2");
    op(0, 2'd1, 0, 0, "R2 R7");
    op(0, 2'd2, 4, 0, "R2 R8");

    // high ROM window and wrap
    op(0, 2'd0, 'h7E0005, 0, "R3");
    op(0, 2'd2, 'h7E0010, 0, "R3 R8");
    op(0, 2'd0, 'h7E0041, 0, "R3 wrap");
    check("R3", "wrap model", 32'(ref_byte('h7E0041)), 32'(rom_ref(1)));

    // RAM
    op(0, 2'd0, 'h30, 0, "R4 reset value");
    op(1, 2'd1, 'h10, 32'h0000BEEF, "R7");
    op(0, 2'd0, 'h10, 0, "R7 high byte");
    op(0, 2'd0, 'h11, 0, "R7 low byte");
    op(1, 2'd2, 'h40, 32'h12345678, "R8");
    op(0, 2'd1, 'h42, 0, "R8 low half");
    op(0, 2'd3, 'h40, 0, "R8 long");
    op(0, 2'd0, 'h1000, 0, "R4 unpopulated");
    op(0, 2'd1, 'h7DFFFE, 0, "R4 unpopulated word");
    op(1, 2'd0, 'h1000, 32'h55, "R4 write");
    op(0, 2'd0, 'h1000, 0, "R4 write dropped");
    check("R4", "fill model", 32'(ref_byte('h1000)), 32'h000000FF);

    // ROM writes dropped
    op(1, 2'd0, 2, 32'h77, "R5");
    op(0, 2'd0, 2, 0, "R5 low alias unchanged");
    op(1, 2'd1, 'h7E0004, 32'h9999, "R5");
    op(0, 2'd1, 'h7E0004, 0, "R5 high window unchanged");

    // device region
    dq.delete();
    op(0, 2'd0, 'h800010, 0, "R6 byte");
    expect_dev("R6", 1, 'h800010, 1'b0);
    dq.delete();
    op(1, 2'd1, 'h800020, 32'h0000CAFE, "R6 word write");
    expect_dev("R6", 1, 'h800020, 1'b1);
    op(0, 2'd1, 'h800020, 0, "R6 R7 word read");
    dq.delete();
    op(0, 2'd2, 'h800100, 0, "R6 R8 long");
    expect_dev("R6", 2, 'h800100, 1'b1);
    if (dq.size() == 2) begin
      check("R6", "second word address", 32'(dq[1].a), 32'h00800102);
      check("R6", "second word width", 32'(dq[1].wide), 1);
    end
    dq.delete();
    op(1, 2'd0, 'h800031, 32'h0000005D, "R6 byte write");
    expect_dev("R6", 1, 'h800031, 1'b0);
    check("R6", "device byte stored", 32'(dev_byte('h800031)), 32'h5D);

    // straddling word
    dq.delete();
    op(0, 2'd1, 'h7FFFFF, 0, "R12");
    expect_dev("R12", 1, 'h800000, 1'b0);

    // request during busy is ignored
    wait_idle;
    start(0, 2'd2, 'h40, 0, "R10 long");
    check("R10", "busy while running", 32'(busy), 1);
    req = 1'b1; we = 1'b1; size = 2'd0; addr = 24'h000020; wdata = 32'h5A;
    @(negedge clk);
    req = 1'b0;
    wait_idle;
    repeat (3) @(negedge clk);
    op(0, 2'd0, 'h20, 0, "R10 ignored write");

    summary;
    $finish;
  end

endmodule